// File: doc/BRIEF.md
# Three-Port Bridge Claim and Delayed-Transaction Tracker

This block sits beside the bus interfaces of a bridge with one upstream port and two peer downstream ports. For every cycle that an initiator starts on one of the three ports, the block decides whether the bridge answers. Its inputs are the originating port, the destination port that the address decode chose, whether the cycle may be posted, and, for the upstream bus, whether some other fast or medium agent already drove its device-select. One clock after the request it reports the decision. If the bridge claims the cycle, it raises the device-select of the originating port and signals either normal completion or retry. It also tells the forwarding datapath when a copy of the cycle must be sent to the destination port.

Cycles that cannot be posted are retried and recorded as pending delayed transactions. Each direction has its own tracker: one for cycles that come from upstream and one for cycles that come from either downstream port. The forwarding datapath reports when a forwarded copy has finished by presenting the originating port, address and command of that copy. When the initiator repeats the identical cycle after that report, the bridge completes it normally and frees the entry. A repeat that arrives earlier is retried again. When a tracker is full, a new non-postable cycle is retried and nothing is recorded.

Top module: `tri_bridge_claim`

## Requirements
- R1: Port codes are 0 for upstream, 1 for downstream A, 2 for downstream B and 3 for no port. A cycle from upstream whose destination is upstream is not claimed: `rsp_claim`=0, `dev_sel`=0, `rsp_abort`=0.
- R2: A cycle from upstream is never claimed and never flagged as abort while `up_other_sel` is high, whatever its destination.
- R3: A cycle from upstream to downstream A or B, with `up_other_sel` low, is claimed with `dev_sel`=3'b001. If it can be posted it completes normally (`rsp_retry`=0) and `fwd_valid` is raised with `fwd_port` equal to the destination.
- R4: A cycle from upstream whose destination is port 3, with `up_other_sel` low, is not claimed and raises `rsp_abort`.
- R5: A cycle from a downstream port whose destination is that same port, or port 3, is not claimed and does not raise `rsp_abort`.
- R6: A cycle from downstream A or B to upstream or to the other downstream port is claimed on its own device-select bit (bit 1 for A, bit 2 for B). `up_other_sel` has no effect on it.
- R7: A claimed non-postable cycle that matches no pending entry, while its direction's tracker has a free entry, is retried, recorded, and forwarded once (`fwd_valid`=1).
- R8: A repeat of a pending cycle whose forwarded copy has not yet completed is retried again and is not forwarded again.
- R9: A repeat of a pending cycle after its completion is reported (`cpl_valid` with equal port, address and command) completes normally, without a forward, and frees the entry. An identical cycle after that counts as new.
- R10: A cycle matches a pending entry only when originating port, address and command are all equal.
- R11: When the tracker of the cycle's direction holds DEPTH entries, a new non-postable claimed cycle is retried without being recorded or forwarded.
- R12: Upstream-origin and downstream-origin cycles use separate trackers of DEPTH entries each. Filling one tracker does not affect the other.
- R13: Every response appears exactly one clock after `req_valid`. `dev_sel` has at most one bit set, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A cycle starts this clock |
| req_src | input | 2 | Originating port code |
| req_dst | input | 2 | Decoded destination port code |
| req_addr | input | ADDR_W | Cycle address |
| req_cmd | input | CMD_W | Cycle command |
| req_postable | input | 1 | Cycle may be posted |
| up_other_sel | input | 1 | Another agent drove upstream device-select |
| cpl_valid | input | 1 | A forwarded delayed copy has finished |
| cpl_src | input | 2 | Originating port of the finished copy |
| cpl_addr | input | ADDR_W | Address of the finished copy |
| cpl_cmd | input | CMD_W | Command of the finished copy |
| rsp_valid | output | 1 | Response for the previous clock's request |
| rsp_claim | output | 1 | Bridge claims the cycle |
| rsp_retry | output | 1 | Claimed cycle ends with retry |
| rsp_abort | output | 1 | Unclaimed upstream cycle ends as master abort |
| dev_sel | output | 3 | Per-port device-select, bit index equals port code |
| fwd_valid | output | 1 | Send a copy of the cycle to the destination |
| fwd_port | output | 2 | Destination port of the copy (0 when no copy is sent) |

## Verification
The bench aims at the asymmetric routing corners: upstream-to-upstream, downstream-to-same-port, and the two kinds of no-destination cycle. A wrong design would claim one of these or confuse abort with a silent no-claim. It also repeats pending cycles before and after their completion, and changes only the command or only the originating port. A broken tracker would then complete too early, forward twice, or merge distinct cycles. It fills one direction's tracker and checks that the next new cycle is retried without a forward, while the other direction still accepts entries. A design that shared one tracker or recorded past capacity would fail these checks.

// File: rtl/tri_bridge_pkg.sv
package tri_bridge_pkg;
  localparam logic [1:0] P_UP   = 2'd0;
  localparam logic [1:0] P_DNA  = 2'd1;
  localparam logic [1:0] P_DNB  = 2'd2;
  localparam logic [1:0] P_NONE = 2'd3;
  localparam int unsigned N_PORTS = 3;
  localparam int unsigned N_DIRS  = 2;

  typedef struct packed {
    logic               claim;
    logic               abort;
    logic [N_PORTS-1:0] sel;
  } route_t;

  function automatic logic dir_of(input logic [1:0] src);
    return (src == P_UP) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/tri_bridge_route.sv
module tri_bridge_route
  import tri_bridge_pkg::*;
(
  input  logic [1:0] src,
  input  logic [1:0] dst,
  input  logic       other_sel,
  output route_t     route
);
  always_comb begin
    route = '0;
    if (src == P_UP) begin
      if (!other_sel) begin
        if ((dst == P_DNA) || (dst == P_DNB)) route.claim = 1'b1;
        else if (dst == P_NONE)               route.abort = 1'b1;
      end
    end else if (src != P_NONE) begin
      if ((dst != P_NONE) && (dst != src)) route.claim = 1'b1;
    end
    if (route.claim) route.sel = N_PORTS'(3'b001 << src);
  end
endmodule

// File: rtl/tri_bridge_dtrack.sv
module tri_bridge_dtrack #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [1:0]        lk_src,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [CMD_W-1:0]  lk_cmd,
  input  logic              cp_valid,
  input  logic [1:0]        cp_src,
  input  logic [ADDR_W-1:0] cp_addr,
  input  logic [CMD_W-1:0]  cp_cmd,
  output logic              lk_hit,
  output logic              lk_done,
  output logic              lk_alloc
);
  logic [DEPTH-1:0]  vld_q, vld_d, done_q, done_d;
  logic [DEPTH-1:0]  lk_m, cp_m, free_v, alloc_oh, load_en;
  logic [1:0]        src_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [CMD_W-1:0]  cmd_q  [DEPTH];
  logic              full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign lk_m[g] = vld_q[g] && (src_q[g] == lk_src) &&
                     (addr_q[g] == lk_addr) && (cmd_q[g] == lk_cmd);
    assign cp_m[g] = vld_q[g] && !done_q[g] && (src_q[g] == cp_src) &&
                     (addr_q[g] == cp_addr) && (cmd_q[g] == cp_cmd);
    assign load_en[g] = lk_alloc && alloc_oh[g];

    always_ff @(posedge clk) begin
      if (load_en[g]) begin
        src_q[g]  <= lk_src;
        addr_q[g] <= lk_addr;
        cmd_q[g]  <= lk_cmd;
      end
    end
  end

  assign full     = &vld_q;
  assign free_v   = ~vld_q;
  assign alloc_oh = free_v & (~free_v + DEPTH'(1));
  assign lk_hit   = |lk_m;
  assign lk_done  = |(lk_m & done_q);
  assign lk_alloc = lk_valid && !lk_hit && !full;

  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    if (cp_valid) done_d = done_d | cp_m;
    if (lk_valid && lk_done) begin
      vld_d  = vld_d & ~(lk_m & done_q);
      done_d = done_d & ~(lk_m & done_q);
    end
    if (lk_alloc) begin
      vld_d  = vld_d | alloc_oh;
      done_d = done_d & ~alloc_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/tri_bridge_claim.sv
module tri_bridge_claim
  import tri_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_src,
  input  logic [1:0]        req_dst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              req_postable,
  input  logic              up_other_sel,
  input  logic              cpl_valid,
  input  logic [1:0]        cpl_src,
  input  logic [ADDR_W-1:0] cpl_addr,
  input  logic [CMD_W-1:0]  cpl_cmd,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_retry,
  output logic              rsp_abort,
  output logic [2:0]        dev_sel,
  output logic              fwd_valid,
  output logic [1:0]        fwd_port
);
  route_t            route;
  logic              req_dir, cpl_dir, delayed;
  logic [N_DIRS-1:0] hit_v, done_v, alloc_v;
  logic              hit, done, alloc;
  logic              valid_d, claim_d, retry_d, abort_d, fwd_d;
  logic [2:0]        sel_d;
  logic [1:0]        port_d;

  tri_bridge_route u_route (
    .src      (req_src),
    .dst      (req_dst),
    .other_sel(up_other_sel),
    .route    (route)
  );

  assign req_dir = dir_of(req_src);
  assign cpl_dir = dir_of(cpl_src);
  assign delayed = req_valid && route.claim && !req_postable;

  for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
    tri_bridge_dtrack #(
      .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DEPTH(DEPTH)
    ) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_valid(delayed && (req_dir == 1'(d))),
      .lk_src  (req_src),
      .lk_addr (req_addr),
      .lk_cmd  (req_cmd),
      .cp_valid(cpl_valid && (cpl_dir == 1'(d))),
      .cp_src  (cpl_src),
      .cp_addr (cpl_addr),
      .cp_cmd  (cpl_cmd),
      .lk_hit  (hit_v[d]),
      .lk_done (done_v[d]),
      .lk_alloc(alloc_v[d])
    );
  end

  assign hit   = hit_v[req_dir];
  assign done  = done_v[req_dir];
  assign alloc = alloc_v[req_dir];

  always_comb begin
    valid_d = req_valid;
    claim_d = req_valid && route.claim;
    abort_d = req_valid && route.abort;
    sel_d   = req_valid ? route.sel : 3'b000;
    retry_d = delayed && !(hit && done);
    fwd_d   = claim_d && (req_postable || alloc);
    port_d  = fwd_d ? req_dst : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_abort <= 1'b0;
      dev_sel   <= 3'b000;
      fwd_valid <= 1'b0;
      fwd_port  <= 2'd0;
    end else begin
      rsp_valid <= valid_d;
      rsp_claim <= claim_d;
      rsp_retry <= retry_d;
      rsp_abort <= abort_d;
      dev_sel   <= sel_d;
      fwd_valid <= fwd_d;
      fwd_port  <= port_d;
    end
  end
endmodule

// File: rtl/tri_bridge_claim_chk.sv
module tri_bridge_claim_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CMD_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_src,
  input logic [1:0]        req_dst,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CMD_W-1:0]  req_cmd,
  input logic              req_postable,
  input logic              up_other_sel,
  input logic              rsp_valid,
  input logic              rsp_claim,
  input logic              rsp_retry,
  input logic              rsp_abort,
  input logic [2:0]        dev_sel,
  input logic              fwd_valid,
  input logic [1:0]        fwd_port
);
  logic up_to_dn, dn_req;
  assign up_to_dn = req_valid && (req_src == 2'd0) && !up_other_sel &&
                    ((req_dst == 2'd1) || (req_dst == 2'd2));
  assign dn_req   = req_valid && ((req_src == 2'd1) || (req_src == 2'd2));

  assert_up_self_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_src == 2'd0) && (req_dst == 2'd0))
      |=> (rsp_valid && !rsp_claim && !rsp_abort && (dev_sel == 3'b000)));

  assert_up_other_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_src == 2'd0) && up_other_sel)
      |=> (!rsp_claim && !rsp_abort && (dev_sel == 3'b000)));

  assert_up_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_to_dn |=> (rsp_claim && (dev_sel == 3'b001)));

  assert_posted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_to_dn && req_postable)
      |=> (!rsp_retry && fwd_valid && (fwd_port == $past(req_dst))));

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_src == 2'd0) && (req_dst == 2'd3) && !up_other_sel)
      |=> (rsp_abort && !rsp_claim));

  assert_dn_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && ((req_dst == req_src) || (req_dst == 2'd3)))
      |=> (!rsp_claim && !rsp_abort && (dev_sel == 3'b000)));

  assert_dn_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && (req_dst != req_src) && (req_dst != 2'd3))
      |=> (rsp_claim && (dev_sel == (3'b001 << $past(req_src)))));

  assert_retry_nonpost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> (rsp_claim && !$past(req_postable)));

  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_sel_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));
endmodule

bind tri_bridge_claim tri_bridge_claim_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
  .req_dst(req_dst), .req_addr(req_addr), .req_cmd(req_cmd),
  .req_postable(req_postable), .up_other_sel(up_other_sel),
  .rsp_valid(rsp_valid), .rsp_claim(rsp_claim), .rsp_retry(rsp_retry),
  .rsp_abort(rsp_abort), .dev_sel(dev_sel), .fwd_valid(fwd_valid),
  .fwd_port(fwd_port)
);

// File: tb/tri_bridge_claim_tb_top.sv
`timescale 1ns/1ps
module tri_bridge_claim_tb_top;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_postable, up_other_sel, cpl_valid;
  logic [1:0] req_src, req_dst, cpl_src;
  logic [AW-1:0] req_addr, cpl_addr;
  logic [CW-1:0] req_cmd, cpl_cmd;
  logic rsp_valid, rsp_claim, rsp_retry, rsp_abort, fwd_valid;
  logic [2:0] dev_sel;
  logic [1:0] fwd_port;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit              mv [2][DP];
  bit              md [2][DP];
  logic [1:0]      ms [2][DP];
  logic [AW-1:0]   ma [2][DP];
  logic [CW-1:0]   mc [2][DP];

  always #2.5 clk = ~clk;

  tri_bridge_claim #(.ADDR_W(AW), .CMD_W(CW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_dst(req_dst), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_postable(req_postable), .up_other_sel(up_other_sel),
    .cpl_valid(cpl_valid), .cpl_src(cpl_src), .cpl_addr(cpl_addr),
    .cpl_cmd(cpl_cmd), .rsp_valid(rsp_valid), .rsp_claim(rsp_claim),
    .rsp_retry(rsp_retry), .rsp_abort(rsp_abort), .dev_sel(dev_sel),
    .fwd_valid(fwd_valid), .fwd_port(fwd_port)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int find(input int d, input logic [1:0] s,
                              input logic [AW-1:0] a, input logic [CW-1:0] c,
                              input bit need_open);
    for (int i = 0; i < DP; i++)
      if (mv[d][i] && ms[d][i] == s && ma[d][i] == a && mc[d][i] == c &&
          (!need_open || !md[d][i])) return i;
    return -1;
  endfunction

  // One request and optional completion; checks outputs one clock later.
  task automatic step(input string tag, input bit v, input logic [1:0] s,
                      input logic [1:0] d, input logic [AW-1:0] a,
                      input logic [CW-1:0] c, input bit post, input bit oth,
                      input bit cv, input logic [1:0] cs,
                      input logic [AW-1:0] ca, input logic [CW-1:0] cc);
    bit claim, abort, retry, fwd;
    logic [2:0] sel;
    int dir, cdir, mi, ci, fi;
    req_valid = v; req_src = s; req_dst = d; req_addr = a; req_cmd = c;
    req_postable = post; up_other_sel = oth;
    cpl_valid = cv; cpl_src = cs; cpl_addr = ca; cpl_cmd = cc;
    claim = 0; abort = 0; retry = 0; fwd = 0; sel = 3'b000;
    if (v) begin
      if (s == 2'd0) begin
        if (!oth && (d == 2'd1 || d == 2'd2)) claim = 1;
        else if (!oth && d == 2'd3) abort = 1;
      end else if (d != 2'd3 && d != s) claim = 1;
      if (claim) sel = 3'(3'b001 << s);
    end
    dir  = (s == 2'd0) ? 0 : 1;
    cdir = (cs == 2'd0) ? 0 : 1;
    ci   = cv ? find(cdir, cs, ca, cc, 1'b1) : -1;
    if (claim && post) fwd = 1;
    if (claim && !post) begin
      mi = find(dir, s, a, c, 1'b0);
      if (mi >= 0 && md[dir][mi]) mv[dir][mi] = 0;
      else begin
        retry = 1;
        if (mi < 0) begin
          fi = -1;
          for (int i = DP - 1; i >= 0; i--) if (!mv[dir][i]) fi = i;
          if (fi >= 0) begin
            fwd = 1; mv[dir][fi] = 1; md[dir][fi] = 0;
            ms[dir][fi] = s; ma[dir][fi] = a; mc[dir][fi] = c;
          end
        end
      end
    end
    if (ci >= 0) md[cdir][ci] = 1;
    @(posedge clk);
    @(negedge clk);
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'(v));
    check({tag, " claim"},     32'(rsp_claim), 32'(claim));
    check({tag, " retry"},     32'(rsp_retry), 32'(retry));
    check({tag, " abort"},     32'(rsp_abort), 32'(abort));
    check({tag, " dev_sel"},   32'(dev_sel),   32'(sel));
    check({tag, " fwd"},       32'(fwd_valid), 32'(fwd));
    check({tag, " fwd_port"},  32'(fwd_port),  fwd ? 32'(d) : 32'd0);
  endtask

  task automatic req(input string tag, input logic [1:0] s, input logic [1:0] d,
                     input logic [AW-1:0] a, input logic [CW-1:0] c,
                     input bit post, input bit oth);
    step(tag, 1'b1, s, d, a, c, post, oth, 1'b0, 2'd0, '0, '0);
  endtask

  task automatic cpl(input string tag, input logic [1:0] s,
                     input logic [AW-1:0] a, input logic [CW-1:0] c);
    step(tag, 1'b0, 2'd0, 2'd0, '0, '0, 1'b0, 1'b0, 1'b1, s, a, c);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0421;
    void'($urandom(seed));
    for (int d = 0; d < 2; d++) for (int i = 0; i < DP; i++) mv[d][i] = 0;
    rst_n = 1'b0; req_valid = 0; req_src = 0; req_dst = 0; req_addr = 0;
    req_cmd = 0; req_postable = 0; up_other_sel = 0; cpl_valid = 0;
    cpl_src = 0; cpl_addr = 0; cpl_cmd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 reset outputs",
          32'({rsp_valid, rsp_claim, rsp_retry, rsp_abort, dev_sel, fwd_valid, fwd_port}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    req("R1 up to up", 2'd0, 2'd0, 32'h10, 4'h6, 1'b1, 1'b0);
    req("R2 other responder", 2'd0, 2'd1, 32'h10, 4'h6, 1'b1, 1'b1);
    req("R2 other responder none", 2'd0, 2'd3, 32'h10, 4'h6, 1'b0, 1'b1);
    req("R4 up no destination", 2'd0, 2'd3, 32'h10, 4'h6, 1'b1, 1'b0);
    req("R3 up to B posted", 2'd0, 2'd2, 32'h20, 4'h7, 1'b1, 1'b0);
    req("R5 A to A", 2'd1, 2'd1, 32'h20, 4'h7, 1'b1, 1'b0);
    req("R5 B to none", 2'd2, 2'd3, 32'h20, 4'h7, 1'b0, 1'b0);
    req("R6 A to up", 2'd1, 2'd0, 32'h30, 4'h7, 1'b1, 1'b1);
    req("R6 B to A", 2'd2, 2'd1, 32'h30, 4'h7, 1'b1, 1'b0);

    req("R7 new delayed", 2'd0, 2'd1, 32'h55, 4'h2, 1'b0, 1'b0);
    req("R8 early repeat", 2'd0, 2'd1, 32'h55, 4'h2, 1'b0, 1'b0);
    req("R10 other command", 2'd0, 2'd1, 32'h55, 4'h3, 1'b0, 1'b0);
    req("R10 src A", 2'd1, 2'd0, 32'h55, 4'h2, 1'b0, 1'b0);
    req("R10 src B", 2'd2, 2'd0, 32'h55, 4'h2, 1'b0, 1'b0);
    cpl("R9 completion", 2'd0, 32'h55, 4'h2);
    req("R9 repeat after completion", 2'd0, 2'd1, 32'h55, 4'h2, 1'b0, 1'b0);
    req("R9 identical again is new", 2'd0, 2'd1, 32'h55, 4'h2, 1'b0, 1'b0);

    for (int i = 0; i < DP; i++)
      req("R11 fill upstream tracker", 2'd0, 2'd2, 32'h100 + 32'(i), 4'h1, 1'b0, 1'b0);
    req("R11 full retried unrecorded", 2'd0, 2'd2, 32'h200, 4'h1, 1'b0, 1'b0);
    req("R12 other direction free", 2'd1, 2'd2, 32'h200, 4'h1, 1'b0, 1'b0);
    cpl("R11 complete one", 2'd0, 32'h100, 4'h1);
    req("R11 drain one", 2'd0, 2'd2, 32'h100, 4'h1, 1'b0, 1'b0);
    req("R11 new after drain", 2'd0, 2'd2, 32'h200, 4'h1, 1'b0, 1'b0);

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] s, d, cs;
      s  = 2'($urandom % 3);
      d  = 2'($urandom % 4);
      cs = 2'($urandom % 3);
      step("R13 random", ($urandom % 8) != 0, s, d, 32'($urandom % 6),
           4'($urandom % 2), ($urandom % 3) == 0, ($urandom % 6) == 0,
           ($urandom % 3) == 0, cs, 32'($urandom % 6), 4'($urandom % 2));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule